// File: doc/BRIEF.md
# Two-Read One-Write Register File

A general-purpose register array for a simple in-order RISC-style pipeline. It holds 32 words of 32 bits. The decode stage reads two operands through two independent combinational read ports. The writeback stage stores one result per clock through a synchronous write port. Entry 0 is a constant zero: it always reads as zero and ignores writes.

A result that is being written back in the same cycle as a read of that entry is forwarded to the read output combinationally. A dependent instruction therefore needs no extra stall cycle for a writeback-to-decode hazard. Forwarding is decided separately for each read port, and it never applies to entry 0.

The active-low reset does not clear the array. An entry that has never been written holds an undefined value, and software must write it before reading it.

Top module: `rf_2r1w`

## Requirements
- R1: The array has 32 entries of 32 bits, selected by 5-bit addresses. There are two read ports (rs1, rs2) and one write port. Every address 1 to 31 can be written and read back on both ports.
- R2: A read of address 0 returns 32'h0 on either port. A write to address 0 is discarded, so entry 0 still reads zero in later cycles.
- R3: When wr_en_i is 1 and wr_addr_i equals a read port's nonzero address, that port outputs wr_data_i in the same cycle.
- R4: With wr_en_i at 1 and wr_addr_i nonzero, wr_data_i is stored on the rising clock edge. Reads in every later cycle return it until the entry is written again.
- R5: rst_ni is active low and does not alter stored entries. Values written before a reset pulse read back unchanged after it.
- R6: Both read ports are combinational. A change of read address changes the read data with no clock edge in between.
- R7: Forwarding is evaluated per port. Both ports can forward the same write data in the same cycle, and a port whose address differs from wr_addr_i returns the stored value.
- R8: With wr_en_i at 0, no entry changes and no forwarding occurs, whatever wr_addr_i and wr_data_i are.
- R9: Forwarding never applies to address 0. A read of 0 returns zero even while a write to address 0 with nonzero data is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low reset; does not clear storage |
| rs1_addr_i | input | 5 | Read port 1 address |
| rs1_data_o | output | 32 | Read port 1 data |
| rs2_addr_i | input | 5 | Read port 2 address |
| rs2_data_o | output | 32 | Read port 2 data |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write address |
| wr_data_i | input | 32 | Write data |

## Verification
The bench builds the block with its default parameters: 32 entries of 32 bits and two read ports. With a 5-bit address space every address can be swept on both read ports and on the write port within a few hundred cycles. This covers back-to-back writes read with lags of one and two cycles, forwarding on both ports at once at every address, writes to entry 0 with all-ones data, and idle cycles with live write address and data. A reference model records which entries have been written and compares only those entries, so the undefined contents after reset are never checked.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_DEPTH = 32;
  localparam int unsigned RF_WIDTH = 32;
  localparam int unsigned RF_NRD   = 2;

  // Read mux source selection
  typedef enum logic [1:0] {
    SRC_ZERO   = 2'd0,
    SRC_FWD    = 2'd1,
    SRC_ARRAY  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int unsigned DEPTH  = rf_pkg::RF_DEPTH,
  parameter int unsigned WIDTH  = rf_pkg::RF_WIDTH,
  parameter int unsigned NRD    = rf_pkg::RF_NRD,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    wa_i,
  input  logic [WIDTH-1:0] wd_i,
  input  logic [AW-1:0]    ra_i [NRD],
  output logic [WIDTH-1:0] rd_o [NRD]
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  // No reset on the array: storage stays as is across rst_ni
  always_ff @(posedge clk_i) begin
    if (we_i && (wa_i != '0)) mem_q[wa_i] <= wd_i;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_o[p] = mem_q[ra_i[p]];

    p_idle_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(!we_i) && $stable(ra_i[p])) |-> $stable(rd_o[p]));
  end

  p_write_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (wa_i != '0)) |=> (mem_q[$past(wa_i)] == $past(wd_i)));
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned DEPTH = rf_pkg::RF_DEPTH,
  parameter int unsigned WIDTH = rf_pkg::RF_WIDTH,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] array_i,
  input  logic             we_i,
  input  logic [AW-1:0]    wa_i,
  input  logic [WIDTH-1:0] wd_i,
  output logic [WIDTH-1:0] data_o
);
  import rf_pkg::*;

  rd_src_e src;

  always_comb begin
    if (addr_i == '0)                       src = SRC_ZERO;
    else if (we_i && (wa_i == addr_i))      src = SRC_FWD;
    else                                    src = SRC_ARRAY;
  end

  always_comb begin
    unique case (src)
      SRC_ZERO: data_o = '0;
      SRC_FWD:  data_o = wd_i;
      default:  data_o = array_i;
    endcase
  end

  p_zero_reads_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == '0) |-> (data_o == '0));

  p_no_fwd_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i) |-> (data_o == ((addr_i == '0) ? '0 : array_i)));
endmodule

// File: rtl/rf_2r1w.sv
module rf_2r1w #(
  parameter int unsigned DEPTH = rf_pkg::RF_DEPTH,
  parameter int unsigned WIDTH = rf_pkg::RF_WIDTH,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned NRD  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    rs1_addr_i,
  output logic [WIDTH-1:0] rs1_data_o,
  input  logic [AW-1:0]    rs2_addr_i,
  output logic [WIDTH-1:0] rs2_data_o,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i
);
  logic [AW-1:0]    ra   [NRD];
  logic [WIDTH-1:0] raw  [NRD];
  logic [WIDTH-1:0] rdat [NRD];

  assign ra[0] = rs1_addr_i;
  assign ra[1] = rs2_addr_i;
  assign rs1_data_o = rdat[0];
  assign rs2_data_o = rdat[1];

  rf_storage #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NRD(NRD)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (wr_en_i),
    .wa_i  (wr_addr_i),
    .wd_i  (wr_data_i),
    .ra_i  (ra),
    .rd_o  (raw)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_port
    rf_read_port #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .addr_i (ra[p]),
      .array_i(raw[p]),
      .we_i   (wr_en_i),
      .wa_i   (wr_addr_i),
      .wd_i   (wr_data_i),
      .data_o (rdat[p])
    );
  end

  p_fwd_rs1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i == rs1_addr_i) && (rs1_addr_i != '0)) |-> (rs1_data_o == wr_data_i));

  p_fwd_both_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i != '0) && (rs1_addr_i == wr_addr_i) && (rs2_addr_i == wr_addr_i))
      |-> (rs1_data_o == rs2_data_o));

  p_zero_during_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i == '0) && (rs2_addr_i == '0)) |-> (rs2_data_o == '0));

  p_persist_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i != '0) && (rs1_addr_i == wr_addr_i)) |=>
      (($past(rs1_addr_i) == rs1_addr_i) |-> (rs1_data_o == (wr_en_i && wr_addr_i == rs1_addr_i ? wr_data_i : $past(wr_data_i)))));
endmodule

// File: tb/rf_2r1w_test.sv
`timescale 1ns/1ps
module rf_2r1w_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  a1 = '0, a2 = '0, wa = '0;
  logic [31:0] d1, d2, wd = '0;
  logic        we = 1'b0;

  logic [31:0] model [32];
  bit          written [32];
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rf_2r1w uut (
    .clk_i(clk), .rst_ni(rst_n),
    .rs1_addr_i(a1), .rs1_data_o(d1),
    .rs2_addr_i(a2), .rs2_data_o(d2),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd)
  );

  // Expected read value; returns 0 in known when entry unwritten and not forwarded
  function automatic bit expect_rd(input logic [4:0] a, output logic [31:0] v);
    if (a == 0) begin v = '0; return 1; end
    if (we && wa == a) begin v = wd; return 1; end
    v = model[a];
    return written[a];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_ports(input string req);
    logic [31:0] e;
    if (expect_rd(a1, e)) chk({req, " rs1"}, d1, e);
    if (expect_rd(a2, e)) chk({req, " rs2"}, d2, e);
  endtask

  // One cycle: drive at negedge, check before the edge, update model at the edge
  task automatic cycle(input logic w, input logic [4:0] wadr, input logic [31:0] wdat,
                       input logic [4:0] r1, input logic [4:0] r2, input string req);
    @(negedge clk);
    we = w; wa = wadr; wd = wdat; a1 = r1; a2 = r2;
    #1;
    check_ports(req);
    @(posedge clk);
    if (w && wadr != 0) begin model[wadr] = wdat; written[wadr] = 1; end
  endtask

  function automatic logic [31:0] pat(input int i, input int salt);
    return (32'h9E37_79B9 * (i + 1)) ^ (salt << 24) ^ i;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin model[i] = '0; written[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    a1 = 0; a2 = 0; #1;
    chk("R2 reset rs1", d1, 32'h0);
    chk("R2 reset rs2", d2, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R4: back-to-back writes, reads lagging by one and two cycles
    for (int i = 0; i < 40; i++)
      cycle(1'b1, 5'(i), pat(i, 1), 5'(i - 1), 5'(i - 2), "R4 lagged");

    // R3/R7: both ports forward same write
    for (int i = 0; i < 32; i++)
      cycle(1'b1, 5'(i), pat(i, 2), 5'(i), 5'(i), "R3 R7 fwd both");

    // R7: only one port matches
    for (int i = 1; i < 32; i++)
      cycle(1'b1, 5'(i), pat(i, 3), 5'(i), 5'(i ^ 1), "R7 one port");

    // R9/R2: write all-ones to entry 0
    cycle(1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0, "R9 zero fwd");
    cycle(1'b0, 5'd0, 32'h0, 5'd0, 5'd0, "R2 zero after write");

    // R8: idle with live address/data, no forwarding, no change
    for (int i = 1; i < 32; i++)
      cycle(1'b0, 5'(i), ~pat(i, 3), 5'(i), 5'(i), "R8 idle");
    for (int i = 1; i < 32; i++)
      cycle(1'b0, 5'd0, 32'h0, 5'(i), 5'(31 - i + 1), "R8 after idle");

    // R5: reset pulse keeps contents
    @(negedge clk); rst_n = 1'b0; we = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 32; i++)
      cycle(1'b0, 5'd0, 32'h0, 5'(i), 5'(i), "R5 keep");

    // R1: exhaustive write/readback on both ports
    for (int i = 1; i < 32; i++)
      cycle(1'b1, 5'(i), pat(i, 4) ^ 32'h5A5A_0000, 5'd0, 5'd0, "R1 fill");
    for (int i = 0; i < 32; i++)
      cycle(1'b0, 5'd0, 32'h0, 5'(i), 5'(31 - i), "R1 readback");

    // R6: address change without a clock edge
    @(negedge clk);
    we = 0;
    for (int i = 0; i < 32; i++) begin
      a1 = 5'(i); a2 = 5'(i + 7);
      #0.2;
      check_ports("R6 comb");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule